// File: doc/BRIEF.md
# Integer Load Address and Extension Unit

This unit carries out the integer load operations of a 32-bit pipeline. It takes a decoded load request and forms the effective address in one of two ways. The displacement form adds a sign-extended 16-bit immediate to the base operand. The indexed form adds the base operand to an index operand. The unit then issues one aligned word read to a synchronous data memory. From the returned word it selects the addressed byte, halfword or word and extends it to 32 bits. Finally it presents a write-back request for the destination register.

Update forms also return the effective address as a second write-back, aimed at the base register, in the same cycle as the data. There are two halfword variants. One fills the upper bits with zeros and the other copies bit 15 into them. Byte and word loads always zero-fill. Memory is big-endian: byte offset 0 is bits 31:24. A halfword or word request that is not aligned to its size is refused. It reads nothing and writes nothing, and reports an alignment error one cycle after it is accepted.

The request side uses a valid/ready handshake. A good load occupies the unit for two cycles. A refused load occupies it for one.

Top module: `int_load_unit`

## Requirements
- R1: In displacement form (`reqIndexed`=0) the effective address is `opA` plus `disp` sign-extended to 32 bits. `memAddr` carries that address with bits 1:0 cleared, and `wbEa` reports the full address.
- R2: In indexed form (`reqIndexed`=1) the effective address is `opA + opB`, and `disp` has no effect.
- R3: A byte load (`reqSize`=0) returns the big-endian byte lane in bits 7:0 with zeros above. Offset 0 selects bits 31:24 of the word and offset 3 selects bits 7:0.
- R4: A halfword load (`reqSize`=1) with `reqSigned`=0 returns bits 31:16 for offset 0 and bits 15:0 for offset 2, with zeros above.
- R5: A halfword load with `reqSigned`=1 copies bit 15 of the selected halfword into bits 31:16 of the result.
- R6: A word load (`reqSize`=2) returns the memory word unchanged.
- R7: When `reqUpdate`=1, `wbRaEn` is raised together with `wbRdEn`. `wbRa` then names the base register and `wbEa` holds the effective address. When `reqUpdate`=0, `wbRaEn` stays low.
- R8: A halfword at an odd address, or a word at an address whose bits 1:0 are not 00, is misaligned. It raises no `memRdEn`. One cycle after acceptance it produces `wbValid` and `alignErr` with `wbRdEn`=0 and `wbRaEn`=0, and `reqReady` stays high.
- R9: For an aligned load, `memRdEn` is high in the accepting cycle. `reqReady` is low in the next cycle, while the read data is returned. The single-cycle `wbValid` pulse comes one cycle after that, which is two clock edges after acceptance.
- R10: `reqSigned` has no effect on byte and word loads: both always zero-fill.
- R11: After reset, `wbValid`, `wbRdEn`, `wbRaEn` and `alignErr` are low and `reqReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Load request present |
| reqReady | output | 1 | Unit can accept a request |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 word |
| reqSigned | input | 1 | Sign-extend halfword result |
| reqIndexed | input | 1 | 1: opA+opB, 0: opA+disp |
| reqUpdate | input | 1 | Write effective address to base register |
| reqRd | input | 5 | Destination register index |
| reqRa | input | 5 | Base register index |
| opA | input | 32 | Base operand |
| opB | input | 32 | Index operand |
| disp | input | 16 | Signed displacement |
| memRdEn | output | 1 | Memory read strobe |
| memAddr | output | 32 | Word-aligned read address |
| memRdData | input | 32 | Read data, valid the cycle after memRdEn |
| wbValid | output | 1 | Result/completion pulse |
| wbRdEn | output | 1 | Write loaded data to destination |
| wbRd | output | 5 | Destination register index |
| wbData | output | 32 | Extended load data |
| wbRaEn | output | 1 | Write effective address to base |
| wbRa | output | 5 | Base register index |
| wbEa | output | 32 | Effective address |
| alignErr | output | 1 | Misaligned request reported |

## Verification
`memRdEn` and `memAddr` are combinational from the request, so they are checked before the accepting edge. A good load's write-back is due after the second edge following acceptance, and the bench samples it on the falling edge after that second edge. A refused load's error is due after the first edge, and it is sampled on the falling edge after that one. One sample later, `wbValid` must be low again, which shows that the completion is a single pulse.

// File: rtl/ldu_pkg.sv
package ldu_pkg;
  localparam int XLEN = 32;
  localparam int DISP_W = 16;
  localparam int REG_IDX_W = 5;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } ldSize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic issue;    // accept aligned request, start read
    logic fault;    // accept misaligned request, report error
    logic capture;  // read data present, build result
  } ctrlStrobe_t;
endpackage

// File: rtl/ldu_ctrl.sv
module ldu_ctrl
  import ldu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        misaligned,
  output logic        reqReady,
  output ctrlStrobe_t strobe
);
  typedef enum logic { ST_IDLE, ST_WAIT } ctrlState_e;
  ctrlState_e state, stateNext;

  always_comb begin
    reqReady       = (state == ST_IDLE);
    strobe.issue   = reqReady && reqValid && !misaligned;
    strobe.fault   = reqReady && reqValid && misaligned;
    strobe.capture = (state == ST_WAIT);
    stateNext      = state;
    if (strobe.issue)        stateNext = ST_WAIT;
    else if (strobe.capture) stateNext = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/ldu_datapath.sv
module ldu_datapath
  import ldu_pkg::*;
#(
  parameter int W = XLEN,
  parameter int DW = DISP_W,
  parameter int RW = REG_IDX_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobe_t   strobe,
  input  logic [1:0]    reqSize,
  input  logic          reqSigned,
  input  logic          reqIndexed,
  input  logic          reqUpdate,
  input  logic [RW-1:0] reqRd,
  input  logic [RW-1:0] reqRa,
  input  logic [W-1:0]  opA,
  input  logic [W-1:0]  opB,
  input  logic [DW-1:0] disp,
  output logic          misaligned,
  output logic [W-1:0]  memAddr,
  input  logic [W-1:0]  memRdData,
  output logic          wbValid,
  output logic          wbRdEn,
  output logic [RW-1:0] wbRd,
  output logic [W-1:0]  wbData,
  output logic          wbRaEn,
  output logic [RW-1:0] wbRa,
  output logic [W-1:0]  wbEa,
  output logic          alignErr
);
  localparam int HW = W / 2;
  localparam int BW = 8;
  localparam int OFF_W = $clog2(W / BW);

  logic [W-1:0] dispExt, addend, ea;
  ldSize_e      sizeIn;

  assign dispExt = {{(W-DW){disp[DW-1]}}, disp};
  assign addend  = reqIndexed ? opB : dispExt;
  assign ea      = opA + addend;
  assign sizeIn  = ldSize_e'(reqSize);
  assign memAddr = {ea[W-1:OFF_W], {OFF_W{1'b0}}};

  always_comb begin
    unique case (sizeIn)
      SZ_BYTE: misaligned = 1'b0;
      SZ_HALF: misaligned = ea[0];
      default: misaligned = |ea[OFF_W-1:0];
    endcase
  end

  // request fields held across the read
  ldSize_e          latSize;
  logic             latSigned, latUpdate;
  logic [OFF_W-1:0] latOff;

  always_ff @(posedge clk) begin
    if (strobe.issue) begin
      latSize   <= sizeIn;
      latSigned <= reqSigned;
      latUpdate <= reqUpdate;
      latOff    <= ea[OFF_W-1:0];
    end
  end

  // lane select and extension
  logic [BW-1:0] byteSel;
  logic [HW-1:0] halfSel;
  logic [W-1:0]  extData;

  assign byteSel = memRdData[W-1-BW*int'(latOff) -: BW];
  assign halfSel = latOff[OFF_W-1] ? memRdData[HW-1:0] : memRdData[W-1:HW];

  always_comb begin
    unique case (latSize)
      SZ_BYTE: extData = {{(W-BW){1'b0}}, byteSel};
      SZ_HALF: extData = {{(W-HW){latSigned & halfSel[HW-1]}}, halfSel};
      default: extData = memRdData;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wbValid  <= 1'b0;
      wbRdEn   <= 1'b0;
      wbRaEn   <= 1'b0;
      alignErr <= 1'b0;
    end else begin
      wbValid  <= strobe.capture | strobe.fault;
      wbRdEn   <= strobe.capture;
      wbRaEn   <= strobe.capture & latUpdate;
      alignErr <= strobe.fault;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.issue | strobe.fault) begin
      wbRd <= reqRd;
      wbRa <= reqRa;
      wbEa <= ea;
    end
    if (strobe.capture) wbData <= extData;
  end
endmodule

// File: rtl/int_load_unit.sv
module int_load_unit
  import ldu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [1:0]  reqSize,
  input  logic        reqSigned,
  input  logic        reqIndexed,
  input  logic        reqUpdate,
  input  logic [4:0]  reqRd,
  input  logic [4:0]  reqRa,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic [15:0] disp,
  output logic        memRdEn,
  output logic [31:0] memAddr,
  input  logic [31:0] memRdData,
  output logic        wbValid,
  output logic        wbRdEn,
  output logic [4:0]  wbRd,
  output logic [31:0] wbData,
  output logic        wbRaEn,
  output logic [4:0]  wbRa,
  output logic [31:0] wbEa,
  output logic        alignErr
);
  ctrlStrobe_t strobe;
  logic        misaligned;

  ldu_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .misaligned(misaligned),
    .reqReady(reqReady), .strobe(strobe)
  );

  ldu_datapath #(.W(XLEN), .DW(DISP_W), .RW(REG_IDX_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqSize(reqSize), .reqSigned(reqSigned), .reqIndexed(reqIndexed),
    .reqUpdate(reqUpdate), .reqRd(reqRd), .reqRa(reqRa),
    .opA(opA), .opB(opB), .disp(disp),
    .misaligned(misaligned), .memAddr(memAddr), .memRdData(memRdData),
    .wbValid(wbValid), .wbRdEn(wbRdEn), .wbRd(wbRd), .wbData(wbData),
    .wbRaEn(wbRaEn), .wbRa(wbRa), .wbEa(wbEa), .alignErr(alignErr)
  );

  assign memRdEn = strobe.issue;
endmodule

// File: rtl/ldu_checker.sv
module ldu_checker (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqReady,
  input logic        memRdEn,
  input logic [31:0] memAddr,
  input logic        wbValid,
  input logic        wbRdEn,
  input logic        wbRaEn,
  input logic        alignErr
);
  // R1
  word_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> memAddr[1:0] == 2'b00);

  // R9
  busy_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !reqReady);

  // R9
  result_timing_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> ##1 (wbValid && wbRdEn && !alignErr));

  // R8
  fault_timing_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !memRdEn) |=> (wbValid && alignErr && reqReady));

  // R8
  fault_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    alignErr |-> (!wbRdEn && !wbRaEn));

  // R7
  update_pairs_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbRaEn |-> wbRdEn);

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |=> !wbValid);
endmodule

bind int_load_unit ldu_checker i_ldu_checker (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .memRdEn(memRdEn), .memAddr(memAddr), .wbValid(wbValid),
  .wbRdEn(wbRdEn), .wbRaEn(wbRaEn), .alignErr(alignErr)
);

// File: tb/test_int_load_unit.sv
`timescale 1ns/1ps
module test_int_load_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqSize = 2'd0;
  logic        reqSigned = 1'b0, reqIndexed = 1'b0, reqUpdate = 1'b0;
  logic [4:0]  reqRd = 5'd0, reqRa = 5'd0;
  logic [31:0] opA = 32'd0, opB = 32'd0;
  logic [15:0] disp = 16'd0;
  logic        memRdEn;
  logic [31:0] memAddr;
  logic [31:0] memRdData = 32'd0;
  logic        wbValid, wbRdEn, wbRaEn, alignErr;
  logic [4:0]  wbRd, wbRa;
  logic [31:0] wbData, wbEa;

  int checks = 0;
  int errors = 0;
  bit doneFlag = 1'b0;

  always #5 clk = ~clk;

  int_load_unit i_int_load_unit (.*);

  // behavioural memory: word pattern from address bits 5:2
  function automatic logic [31:0] memWord(input logic [31:0] a);
    logic [7:0] i;
    i = {4'd0, a[5:2]};
    return {8'hF0 + i, 8'h10 + i, 8'h5A - i, 8'h21 + i};
  endfunction

  always @(posedge clk) if (memRdEn) memRdData <= memWord(memAddr);

  task automatic ck(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doLoad(input string tag, input logic [1:0] sz, input bit sgn, input bit idx,
                        input bit upd, input logic [31:0] a, input logic [31:0] b,
                        input logic [15:0] d);
    logic [31:0] ea, w, exp;
    bit bad;
    int off;
    ea  = idx ? a + b : a + {{16{d[15]}}, d};
    off = int'(ea[1:0]);
    bad = (sz == 2'd1 && ea[0]) || (sz == 2'd2 && ea[1:0] != 2'b00);
    w   = memWord(ea);
    case (sz)
      2'd0: exp = (w >> (8 * (3 - off))) & 32'hFF;
      2'd1: begin
        exp = (off >= 2) ? (w & 32'hFFFF) : (w >> 16);
        if (sgn && exp[15]) exp = exp | 32'hFFFF_0000;
      end
      default: exp = w;
    endcase
    @(negedge clk);
    reqValid = 1'b1; reqSize = sz; reqSigned = sgn; reqIndexed = idx; reqUpdate = upd;
    reqRd = 5'd7; reqRa = 5'd3; opA = a; opB = b; disp = d;
    #1;
    ck(memRdEn == !bad, {tag, " R8 read strobe"}, 32'(memRdEn), 32'(!bad));
    if (!bad) ck(memAddr == {ea[31:2], 2'b00}, {tag, " R1 memAddr"}, memAddr, {ea[31:2], 2'b00});
    @(negedge clk);
    reqValid = 1'b0;
    if (bad) begin
      ck(wbValid && alignErr && !wbRdEn && !wbRaEn, {tag, " R8 fault"},
         {28'd0, wbValid, alignErr, wbRdEn, wbRaEn}, 32'hC);
      ck(reqReady, {tag, " R8 ready"}, 32'(reqReady), 32'd1);
    end else begin
      ck(!reqReady && !wbValid, {tag, " R9 busy"}, {30'd0, reqReady, wbValid}, 32'd0);
      @(negedge clk);
      ck(wbValid && wbRdEn && !alignErr, {tag, " R9 result due"},
         {29'd0, wbValid, wbRdEn, alignErr}, 32'h6);
      ck(wbData == exp, {tag, " R3 R4 R5 R6 R10 data"}, wbData, exp);
      ck(wbRaEn == upd, {tag, " R7 base enable"}, 32'(wbRaEn), 32'(upd));
      ck(wbEa == ea && wbRa == 5'd3 && wbRd == 5'd7, {tag, " R1 R2 R7 ea/regs"}, wbEa, ea);
    end
    @(negedge clk);
    ck(!wbValid, {tag, " R9 single pulse"}, 32'(wbValid), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    ck(!wbValid && !wbRdEn && !wbRaEn && !alignErr && reqReady, "R11 reset",
       {27'd0, wbValid, wbRdEn, wbRaEn, alignErr, reqReady}, 32'h1);
    rstN = 1'b1;
    // R3 byte lanes, displacement form, positive and negative disp (R1)
    doLoad("R3 byte off0",  2'd0, 0, 0, 0, 32'h100, 32'h0, 16'h0010);
    doLoad("R3 byte off3",  2'd0, 0, 0, 0, 32'h120, 32'h0, 16'hFFFF);
    doLoad("R10 byte sgn",  2'd0, 1, 0, 0, 32'h200, 32'h0, 16'h0000);
    // R4 halfword zero-fill, both offsets, indexed (R2)
    doLoad("R4 half off0",  2'd1, 0, 1, 0, 32'h300, 32'h8, 16'h1234);
    doLoad("R4 half off2",  2'd1, 0, 1, 0, 32'h302, 32'h4, 16'h0000);
    // R5 algebraic halfword, negative and positive halfword
    doLoad("R5 half neg",   2'd1, 1, 0, 1, 32'h40C, 32'h0, 16'h0004);
    doLoad("R5 half pos",   2'd1, 1, 1, 1, 32'h40C, 32'h6, 16'h0000);
    // R6 word, update (R7), R10 sign flag on word
    doLoad("R6 word upd",   2'd2, 0, 1, 1, 32'h1000, 32'h14, 16'h0000);
    doLoad("R10 word sgn",  2'd2, 1, 0, 0, 32'h1000, 32'h0, 16'hFFF8);
    // R8 misaligned halfword and word
    doLoad("R8 half odd",   2'd1, 0, 0, 1, 32'h500, 32'h0, 16'h0003);
    doLoad("R8 word off2",  2'd2, 0, 1, 0, 32'h500, 32'h2, 16'h0000);
    doLoad("R8 word off1",  2'd2, 1, 0, 1, 32'h501, 32'h0, 16'h0000);
    // aligned after fault
    doLoad("R9 after fault",2'd2, 0, 0, 0, 32'h538, 32'h0, 16'h0000);
    doneFlag = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!doneFlag) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule